// File: doc/BRIEF.md
# Extended Add/Subtract Unit with Carry and Overflow Status

This unit is the carry-chained add and subtract slice of a RISC integer pipeline. Each accepted operation combines operand A, operand B and the stored carry bit through one shared adder. It returns a registered result and updates a three-bit status: carry (CA), overflow (OV) and a sticky summary overflow (SO). The carry-extended family takes part in multi-word arithmetic: add-extended, subtract-from-extended, the minus-one and zero forms of both, and negate.

A width control chooses 64-bit or 32-bit behaviour. In 32-bit mode the adder still produces all 64 result bits, but every carry comparison and sign test looks only at the low 32 bits. An overflow-enable input picks the flag-updating variant of an operation. Without it, OV and SO are left alone.

Top module: `addx_unit`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears CA, OV, SO, the result and out_valid.
- R2: Opcode 0 (add-extended) returns A + B + CA. CA becomes 1 when the result, compared unsigned at the active width, is below A, or when CA was 1 and the result equals A. Otherwise CA becomes 0.
- R3: Opcode 1 (subtract-from-extended) returns B + ~A + CA. CA becomes 0 only when the result is at least B and either CA was 0 or the result differs from B. Otherwise CA becomes 1.
- R4: Opcode 2 (add-minus-one-extended) returns A + CA - 1, and opcode 4 (subtract-from-minus-one-extended) returns ~A + CA - 1. CA is forced to 1 when A is nonzero (opcode 2) or not all ones at the active width (opcode 4). Otherwise CA keeps its value.
- R5: Opcode 3 (add-zero-extended) returns A + CA, with CA set exactly when the result is below A. Opcode 5 (subtract-from-zero-extended) returns ~A + CA, with CA set exactly when the result is below ~A.
- R6: When in_ovf_en is 1, OV takes the signed-overflow outcome: both addends share a sign bit and the result sign differs. OV is cleared when there is no overflow, and SO is set on overflow. When in_ovf_en is 0, OV and SO do not change.
- R7: SO is never cleared by any operation; only reset clears it.
- R8: Opcode 6 (negate) returns the two's complement of A and leaves CA unchanged. If A is the most negative value at the active width, the result is A itself and that case counts as an overflow.
- R9: With in_wide = 0, the sign bit is bit 31 and carry comparisons use the low 32 bits only. The upper 32 result bits still come from the 64-bit arithmetic. With in_wide = 1, the sign bit is bit 63.
- R10: Result and flags change only on a clock edge where in_valid is 1. out_valid is 1 in the cycle after such an edge. When in_valid is 0, out_valid drops to 0 and the result and all flags hold.
- R11: Opcode 7 is reserved. It returns a zero result and changes none of CA, OV or SO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode 0..7 as in the requirements |
| in_ovf_en | input | 1 | Overflow-updating variant |
| in_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| in_a | input | DATA_W | Operand A |
| in_b | input | DATA_W | Operand B |
| out_valid | output | 1 | Result registered in the previous cycle |
| out_result | output | DATA_W | Registered result |
| out_ca | output | 1 | Carry flag |
| out_ov | output | 1 | Overflow flag |
| out_so | output | 1 | Sticky summary overflow |

## Verification
Add-extended is tried with small values, with all-ones plus one, and with a zero result reached only through carry-in. Together these separate the two parts of the carry rule. The same operand pairs are sent in both width modes, so a design that tests bit 63 where bit 31 is meant, or compares all 64 bits, gives a different carry or overflow. The minus-one forms are driven with A at zero, at all ones and at ordinary values, which separates "force to one" from "hold". Negate is tried on the most negative value in each width. Overflow pairs are sent with and without in_ovf_en, and followed by non-overflowing operations, to show that OV clears while SO stays set.

// File: rtl/addx_pkg.sv
package addx_pkg;

    typedef enum logic [2:0] {
        OP_ADDE   = 3'd0,
        OP_SUBFE  = 3'd1,
        OP_ADDME  = 3'd2,
        OP_ADDZE  = 3'd3,
        OP_SUBFME = 3'd4,
        OP_SUBFZE = 3'd5,
        OP_NEG    = 3'd6,
        OP_RSVD   = 3'd7
    } addx_op_e;

    typedef struct packed {
        logic ca;
        logic ov;
        logic so;
    } addx_flags_t;

    // Signed overflow of a two-addend sum given the three sign bits.
    function automatic logic sum_overflow(input logic xs, input logic ys, input logic rs);
        return (xs == ys) && (rs != xs);
    endfunction

    // True for operations that write the carry flag.
    function automatic logic writes_carry(input addx_op_e op);
        return (op != OP_NEG) && (op != OP_RSVD);
    endfunction

endpackage

// File: rtl/addx_operand_sel.sv
module addx_operand_sel
    import addx_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  addx_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              ca,
    output logic [DATA_W-1:0] x,
    output logic [DATA_W-1:0] y,
    output logic              cin
);
    always_comb begin
        x   = '0;
        y   = '0;
        cin = 1'b0;
        unique case (op)
            OP_ADDE:   begin x = a;  y = b;  cin = ca;   end
            OP_SUBFE:  begin x = ~a; y = b;  cin = ca;   end
            OP_ADDME:  begin x = a;  y = '1; cin = ca;   end
            OP_ADDZE:  begin x = a;  y = '0; cin = ca;   end
            OP_SUBFME: begin x = ~a; y = '1; cin = ca;   end
            OP_SUBFZE: begin x = ~a; y = '0; cin = ca;   end
            OP_NEG:    begin x = ~a; y = '0; cin = 1'b1; end
            default:   begin x = '0; y = '0; cin = 1'b0; end
        endcase
    end
endmodule

// File: rtl/addx_adder.sv
module addx_adder #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output logic              xs,
    output logic              ys,
    output logic              rs
);
    localparam int unsigned HI_W = DATA_W - 1;
    localparam int unsigned LO_W = NARROW_W - 1;

    assign sum = x + y + DATA_W'(cin);

    // Sign bit position depends on the active width.
    assign xs = wide ? x[HI_W]   : x[LO_W];
    assign ys = wide ? y[HI_W]   : y[LO_W];
    assign rs = wide ? sum[HI_W] : sum[LO_W];
endmodule

// File: rtl/addx_flag_eval.sv
module addx_flag_eval
    import addx_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  addx_op_e          op,
    input  logic              wide,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] sum,
    input  logic              ca,
    input  logic              xs,
    input  logic              ys,
    input  logic              rs,
    output logic [DATA_W-1:0] res,
    output logic              ca_next,
    output logic              ca_write,
    output logic              ovf,
    output logic              arith
);
    localparam int unsigned PAD_W = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0]   MOST_NEG_W = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [NARROW_W-1:0] MOST_NEG_N = {1'b1, {(NARROW_W-1){1'b0}}};

    function automatic logic [DATA_W-1:0] at_width(input logic [DATA_W-1:0] v, input logic w);
        return w ? v : {{PAD_W{1'b0}}, v[NARROW_W-1:0]};
    endfunction

    logic [DATA_W-1:0] aw, bw, rw, naw, onesw;
    logic              most_neg;

    assign aw    = at_width(a, wide);
    assign bw    = at_width(b, wide);
    assign rw    = at_width(sum, wide);
    assign naw   = at_width(~a, wide);
    assign onesw = at_width('1, wide);
    assign most_neg = wide ? (a == MOST_NEG_W) : (a[NARROW_W-1:0] == MOST_NEG_N);

    assign arith    = (op != OP_RSVD);
    assign ca_write = writes_carry(op);

    always_comb begin
        res     = sum;
        ca_next = ca;
        ovf     = sum_overflow(xs, ys, rs);
        unique case (op)
            OP_ADDE:   ca_next = (rw < aw) || (ca && (rw == aw));
            OP_SUBFE:  ca_next = !((rw >= bw) && (!ca || (rw != bw)));
            OP_ADDME:  ca_next = (aw != '0) ? 1'b1 : ca;
            OP_ADDZE:  ca_next = (rw < aw);
            OP_SUBFME: ca_next = (aw != onesw) ? 1'b1 : ca;
            OP_SUBFZE: ca_next = !(rw >= naw);
            OP_NEG: begin
                ovf = most_neg;
                res = most_neg ? a : sum;
            end
            default: begin
                ovf = 1'b0;
                res = '0;
            end
        endcase
    end
endmodule

// File: rtl/addx_unit.sv
module addx_unit
    import addx_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_ovf_en,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_ca,
    output logic              out_ov,
    output logic              out_so
);
    addx_op_e          op;
    addx_flags_t       flags_q;
    logic [DATA_W-1:0] x, y, sum, res;
    logic              cin, xs, ys, rs;
    logic              ca_next, ca_write, ovf, arith;

    assign op = addx_op_e'(in_op);

    addx_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .op(op), .a(in_a), .b(in_b), .ca(flags_q.ca),
        .x(x), .y(y), .cin(cin)
    );

    addx_adder #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_add (
        .x(x), .y(y), .cin(cin), .wide(in_wide),
        .sum(sum), .xs(xs), .ys(ys), .rs(rs)
    );

    addx_flag_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
        .op(op), .wide(in_wide), .a(in_a), .b(in_b), .sum(sum), .ca(flags_q.ca),
        .xs(xs), .ys(ys), .rs(rs),
        .res(res), .ca_next(ca_next), .ca_write(ca_write), .ovf(ovf), .arith(arith)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= res;
                if (ca_write) flags_q.ca <= ca_next;
                if (in_ovf_en && arith) begin
                    flags_q.ov <= ovf;
                    if (ovf) flags_q.so <= 1'b1;
                end
            end
        end
    end

    assign out_ca = flags_q.ca;
    assign out_ov = flags_q.ov;
    assign out_so = flags_q.so;
endmodule

// File: rtl/addx_unit_checker.sv
module addx_unit_checker #(
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic              in_ovf_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_ca,
    input logic              out_ov,
    input logic              out_so
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: the cycle after a reset edge shows cleared state
    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r1_reset_clear: assert (!out_ca && !out_ov && !out_so && !out_valid && out_result == '0);
        end
    end

    a_r7_so_sticky: assert property (@(posedge clk) disable iff (rst)
        out_so |=> out_so);

    // R6: OV is never set without SO
    a_r6_ov_needs_so: assert property (@(posedge clk) disable iff (rst)
        out_ov |-> out_so);

    a_r6_no_enable_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ovf_en) |=> ($stable(out_ov) && $stable(out_so)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_ca)
                       && $stable(out_ov) && $stable(out_so)));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_neg_keeps_ca: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd6) |=> $stable(out_ca));

    a_r11_reserved_op: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd7) |=> (out_result == '0 && $stable(out_ca)
                                          && $stable(out_ov) && $stable(out_so)));
endmodule

bind addx_unit addx_unit_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_ovf_en(in_ovf_en),
    .out_valid(out_valid), .out_result(out_result), .out_ca(out_ca),
    .out_ov(out_ov), .out_so(out_so)
);

// File: tb/addx_unit_bench.sv
`timescale 1ns/1ps
module addx_unit_bench;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic        in_ovf_en = 1'b0;
    logic        in_wide = 1'b1;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_ca, out_ov, out_so;

    int checks = 0;
    int errors = 0;

    // model state
    logic [63:0] m_res = '0;
    logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;

    // scoreboard: {valid, result, ca, ov, so}
    logic [67:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    addx_unit u_addx_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_ovf_en(in_ovf_en), .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result), .out_ca(out_ca),
        .out_ov(out_ov), .out_so(out_so)
    );

    task automatic send(input logic [2:0] op, input logic en, input logic wide,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
        logic [63:0] x, y, r;
        logic        cin, cy, ov, mn;
        logic [64:0] s64;
        logic [32:0] s32;
        int          k;
        k = wide ? 63 : 31;
        x = a; y = '0; cin = m_ca;
        case (op)
            3'd0: begin x = a;  y = b;    end
            3'd1: begin x = ~a; y = b;    end
            3'd2: begin x = a;  y = ONES; end
            3'd3: begin x = a;  y = '0;   end
            3'd4: begin x = ~a; y = ONES; end
            3'd5: begin x = ~a; y = '0;   end
            default: ;
        endcase
        s64 = {1'b0, x} + {1'b0, y} + 65'(cin);
        s32 = {1'b0, x[31:0]} + {1'b0, y[31:0]} + 33'(cin);
        r   = s64[63:0];
        cy  = wide ? s64[64] : s32[32];
        ov  = (x[k] == y[k]) && (r[k] != x[k]);
        if (op == 3'd6) begin
            mn = wide ? (a == 64'h8000_0000_0000_0000) : (a[31:0] == 32'h8000_0000);
            r  = mn ? a : (~a + 64'd1);
            ov = mn;
            cy = m_ca;
        end
        if (op == 3'd7) begin
            r = '0; cy = m_ca; ov = m_ov;
        end
        m_res = r;
        m_ca  = cy;
        if (en && op != 3'd7) begin
            m_ov = ov;
            if (ov) m_so = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_ovf_en = en; in_wide = wide;
        in_a = a; in_b = b;
        exp_q.push_back({1'b1, m_res, m_ca, m_ov, m_so});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_a = $urandom(); in_b = ONES;
        exp_q.push_back({1'b0, m_res, m_ca, m_ov, m_so});
        tag_q.push_back(tag);
    endtask

    task automatic check_reset();
        checks++;
        if (out_valid !== 1'b0 || out_result !== '0 || out_ca !== 1'b0 ||
            out_ov !== 1'b0 || out_so !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: got v=%b r=%h ca=%b ov=%b so=%b expected all zero",
                     out_valid, out_result, out_ca, out_ov, out_so);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_res = '0; m_ca = 1'b0; m_ov = 1'b0; m_so = 1'b0;
        check_reset(); // R1
    endtask

    // monitor: sample 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [67:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({out_valid, out_result, out_ca, out_ov, out_so} !== e) begin
                    errors++;
                    $display("FAIL %s: got v=%b r=%h ca=%b ov=%b so=%b expected v=%b r=%h ca=%b ov=%b so=%b",
                             t, out_valid, out_result, out_ca, out_ov, out_so,
                             e[67], e[66:3], e[2], e[1], e[0]);
                end
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R2 add-extended
        send(3'd0, 0, 1, 64'd5, 64'd7, "R2 small add");
        send(3'd0, 0, 1, ONES, 64'd1, "R2 wrap sets carry");
        send(3'd0, 0, 1, 64'd0, ONES, "R2 carry-in result equals A");
        send(3'd0, 0, 1, 64'd3, 64'd4, "R2 carry-in added");
        // R6 overflow with enable, R7 sticky SO
        send(3'd0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R6 wide overflow");
        send(3'd0, 1, 1, 64'd1, 64'd1, "R7 OV clears SO stays");
        send(3'd0, 1, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R6 negative overflow");
        send(3'd0, 0, 1, 64'd2, 64'd2, "R6 no enable keeps OV");
        idle("R10 idle hold");
        idle("R10 idle hold 2");
        // R3 subtract-from-extended
        send(3'd0, 0, 1, 64'd1, ONES, "R2 set CA");
        send(3'd1, 0, 1, 64'd3, 64'd10, "R3 B-A with carry");
        send(3'd1, 0, 1, 64'd10, 64'd3, "R3 borrow");
        send(3'd1, 0, 1, 64'd0, 64'd0, "R3 equal without carry");
        send(3'd1, 1, 1, 64'h8000_0000_0000_0000, 64'd0, "R3 R6 subtract overflow");
        do_reset();
        // R4 minus-one forms
        send(3'd2, 0, 1, 64'd0, 64'd0, "R4 addme zero holds CA");
        send(3'd2, 0, 1, 64'd9, 64'd0, "R4 addme nonzero forces CA");
        send(3'd2, 0, 1, 64'd0, 64'd0, "R4 addme zero keeps CA one");
        send(3'd4, 0, 1, ONES, 64'd0, "R4 subfme all ones holds CA");
        send(3'd3, 0, 1, 64'd0, 64'd0, "R5 addze clear CA");
        send(3'd4, 0, 1, ONES, 64'd0, "R4 subfme all ones holds zero");
        send(3'd4, 0, 1, 64'd6, 64'd0, "R4 subfme forces CA");
        send(3'd4, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'd0, "R4 R9 subfme narrow not all ones");
        send(3'd3, 0, 1, 64'd0, 64'd0, "R5 addze clear CA again");
        send(3'd4, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'd0, "R4 R9 subfme narrow all ones holds");
        // R5 zero forms
        send(3'd0, 0, 1, ONES, 64'd1, "R2 set CA");
        send(3'd3, 0, 1, ONES, 64'd0, "R5 addze wraps");
        send(3'd3, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, "R5 addze plain");
        send(3'd5, 0, 1, 64'd5, 64'd0, "R5 subfze no carry");
        send(3'd0, 0, 1, ONES, 64'd1, "R2 set CA");
        send(3'd5, 0, 1, 64'd0, 64'd0, "R5 subfze zero with carry");
        // R8 negate
        send(3'd6, 1, 1, 64'd5, 64'd0, "R8 negate five");
        send(3'd6, 1, 1, 64'h8000_0000_0000_0000, 64'd0, "R8 wide most negative");
        do_reset();
        send(3'd6, 1, 0, 64'h0000_0000_8000_0000, 64'd0, "R8 R9 narrow most negative");
        send(3'd6, 1, 0, 64'h8000_0000_0000_0000, 64'd0, "R8 R9 narrow not most negative");
        // R9 narrow mode flags from low half
        do_reset();
        send(3'd0, 1, 0, 64'h0000_0001_FFFF_FFFF, 64'd1, "R9 narrow carry upper bits");
        send(3'd0, 1, 1, 64'h0000_0001_FFFF_FFFF, 64'd1, "R9 wide no carry");
        send(3'd0, 1, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, "R9 narrow overflow");
        send(3'd0, 1, 1, 64'h0000_0000_7FFF_FFFF, 64'd1, "R9 wide no overflow");
        // R11 reserved opcode
        send(3'd7, 1, 1, ONES, ONES, "R11 reserved");
        idle("R10 idle after reserved");
        idle("R10 drain");
        idle("R10 drain");
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule